// File: doc/BRIEF.md
# Double to Signed Integer Truncator

This block turns one IEEE-754 binary64 value into a signed two's-complement integer. The fractional part is always dropped toward zero. The result is 32 or 64 bits wide. A pair of mode inputs picks the width: the wide result is produced only when the 64-bit operating mode is on and the wide-select bit is also set. In every other case, including any time the mode is off, the narrow result is used and the wide-select bit has no effect.

Three kinds of input cannot be represented in the selected width: values out of range, NaN and the two infinities. Each of these raises an invalid flag and returns the integer-indefinite pattern, which is the most-negative value of the selected width. When fraction bits that are not all zero are thrown away, an inexact flag is raised instead.

An input is accepted on a cycle where valid and ready are both high. Its result, both flags and a one-cycle valid strobe appear at the output register on the next clock edge.

Top module: `dbl2int_trunc`

## Requirements
- R1: A finite input whose truncated value fits the selected width returns that truncated value, rounded toward zero, as a two's-complement number, and clears the invalid flag.
- R2: The 64-bit result is selected only when in_mode64=1 and in_wide=1. For every other combination the 32-bit conversion is used, and in_wide has no effect while in_mode64=0.
- R3: In 32-bit width, a truncated value below -2^31 or above 2^31-1 sets out_invalid and returns 0x0000_0000_8000_0000. A truncated value of exactly -2^31 (for example -2147483648.9) is valid. +2^31 is invalid.
- R4: In 64-bit width, a truncated value outside [-2^63, 2^63-1] sets out_invalid and returns 0x8000_0000_0000_0000. Exactly -2^63 is valid.
- R5: An input with exponent field bits [62:52] all ones (NaN or infinity, either sign) sets out_invalid and returns the indefinite pattern for the selected width.
- R6: An exponent field of zero returns 0. out_inexact is set when fraction bits [51:0] are nonzero (a denormal) and is clear for +0 and -0.
- R7: out_inexact is set exactly when nonzero fraction bits are discarded from a valid conversion. It is never high together with out_invalid.
- R8: In 32-bit width, out_result[63:32] is zero.
- R9: in_ready is high out of reset. An input accepted at a clock edge gives out_valid=1 with its result after that edge. A cycle with no accepted input gives out_valid=0, and out_result and both flags hold their values.
- R10: While reset is active, out_valid, out_result, out_invalid and out_inexact are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input value present |
| in_ready | output | 1 | Block can take an input |
| in_data | input | 64 | binary64 operand |
| in_mode64 | input | 1 | 64-bit operating mode active |
| in_wide | input | 1 | Request a 64-bit result (honoured only in 64-bit mode) |
| out_valid | output | 1 | Result strobe, one cycle per accepted input |
| out_result | output | 64 | Signed integer result, zero-extended in 32-bit width |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Precision-loss flag |

## Verification
The bench sweeps every unbiased exponent from -3 to 70. At each exponent it drives several mantissa patterns, both signs and all three width selections, and it computes the expected integer with division and remainder on wide integers. This sweep covers the points where the range check breaks. An off-by-one limit would either reject -2^31 and -2^63 or accept +2^31 and +2^63. A wrong shift direction or shift amount at exponents near 52 would corrupt the result or mis-set the inexact flag.

Zeros, denormals, NaN and the infinities are driven on their own. A design that ignored the special exponent would return a garbage magnitude. A design that flagged every zero exponent would mark ±0 as inexact. Idle cycles check that the strobe drops and the result register holds. Driving in_wide high with the mode off shows whether a design leaks the wide select into the result.

// File: rtl/dti_pkg.sv
package dti_pkg;
  localparam int FP_W     = 64;
  localparam int EXP_W    = 11;
  localparam int FRAC_W   = 52;
  localparam int SIG_W    = FRAC_W + 1;
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int UEXP_W   = EXP_W + 2;
  localparam int OUT_W    = 64;
  localparam int NARROW_W = 32;

  // largest magnitude allowed for the chosen width and sign
  function automatic logic [OUT_W-1:0] f_limit(input logic wide, input logic neg);
    logic [OUT_W-1:0] top;
    top = wide ? (OUT_W'(1) << (OUT_W - 1)) : (OUT_W'(1) << (NARROW_W - 1));
    return neg ? top : top - OUT_W'(1);
  endfunction

  // integer-indefinite pattern of the chosen width
  function automatic logic [OUT_W-1:0] f_indef(input logic wide);
    return wide ? (OUT_W'(1) << (OUT_W - 1)) : (OUT_W'(1) << (NARROW_W - 1));
  endfunction

  // two's complement of a magnitude, cut to the chosen width
  function automatic logic [OUT_W-1:0] f_signed(input logic [OUT_W-1:0] mag,
                                               input logic neg, input logic wide);
    logic [OUT_W-1:0] r;
    r = neg ? (~mag + OUT_W'(1)) : mag;
    if (!wide) r[OUT_W-1:NARROW_W] = '0;
    return r;
  endfunction
endpackage

// File: rtl/dti_unpack.sv
module dti_unpack
  import dti_pkg::*;
(
  input  logic [FP_W-1:0]   raw,
  output logic              sign,
  output logic              special,
  output logic              zero_den,
  output logic              frac_nz,
  output logic [UEXP_W-1:0] uexp,
  output logic [SIG_W-1:0]  sig
);
  logic [EXP_W-1:0] exp_f;

  always_comb begin
    exp_f    = raw[FP_W-2 -: EXP_W];
    sign     = raw[FP_W-1];
    special  = &exp_f;
    zero_den = (exp_f == '0);
    frac_nz  = |raw[FRAC_W-1:0];
    uexp     = {2'b00, exp_f} - UEXP_W'(BIAS);
    sig      = {1'b1, raw[FRAC_W-1:0]};
  end
endmodule

// File: rtl/dti_align.sv
module dti_align
  import dti_pkg::*;
(
  input  logic              zero_den,
  input  logic              frac_nz,
  input  logic [UEXP_W-1:0] uexp,
  input  logic [SIG_W-1:0]  sig,
  output logic [OUT_W-1:0]  mag,
  output logic              lost,
  output logic              big
);
  logic [OUT_W-1:0] sigx;
  int               ue;
  int               sh;

  always_comb begin
    sigx = {{(OUT_W-SIG_W){1'b0}}, sig};
    ue   = int'($signed(uexp));
    sh   = 0;
    mag  = '0;
    lost = 1'b0;
    big  = 1'b0;
    if (zero_den) begin
      lost = frac_nz;
    end else if (ue < 0) begin
      lost = 1'b1;
    end else if (ue > OUT_W - 1) begin
      big = 1'b1;
    end else if (ue <= FRAC_W) begin
      sh   = FRAC_W - ue;
      mag  = sigx >> sh;
      lost = |(sigx & ((OUT_W'(1) << sh) - OUT_W'(1)));
    end else begin
      sh  = ue - FRAC_W;
      mag = sigx << sh;
    end
  end
endmodule

// File: rtl/dti_range.sv
module dti_range
  import dti_pkg::*;
(
  input  logic             sign,
  input  logic             special,
  input  logic             big,
  input  logic             lost,
  input  logic             wide,
  input  logic [OUT_W-1:0] mag,
  output logic [OUT_W-1:0] result,
  output logic             invalid,
  output logic             inexact
);
  always_comb begin
    invalid = special | big | (mag > f_limit(wide, sign));
    inexact = !invalid && lost;
    result  = invalid ? f_indef(wide) : f_signed(mag, sign, wide);
  end
endmodule

// File: rtl/dbl2int_trunc.sv
module dbl2int_trunc
  import dti_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [FP_W-1:0]  in_data,
  input  logic             in_mode64,
  input  logic             in_wide,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_result,
  output logic             out_invalid,
  output logic             out_inexact
);
  logic              accept;
  logic              wide_sel;
  logic              f_sign, f_special, f_zero_den, f_frac_nz;
  logic [UEXP_W-1:0] f_uexp;
  logic [SIG_W-1:0]  f_sig;
  logic [OUT_W-1:0]  a_mag;
  logic              a_lost, a_big;
  logic [OUT_W-1:0]  c_result;
  logic              c_invalid, c_inexact;

  assign in_ready = rst_n;
  assign accept   = in_valid && in_ready;
  assign wide_sel = in_mode64 && in_wide;

  dti_unpack u_unpack (
    .raw(in_data), .sign(f_sign), .special(f_special), .zero_den(f_zero_den),
    .frac_nz(f_frac_nz), .uexp(f_uexp), .sig(f_sig)
  );

  dti_align u_align (
    .zero_den(f_zero_den), .frac_nz(f_frac_nz), .uexp(f_uexp), .sig(f_sig),
    .mag(a_mag), .lost(a_lost), .big(a_big)
  );

  dti_range u_range (
    .sign(f_sign), .special(f_special), .big(a_big), .lost(a_lost),
    .wide(wide_sel), .mag(a_mag), .result(c_result), .invalid(c_invalid),
    .inexact(c_inexact)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_result  <= c_result;
        out_invalid <= c_invalid;
        out_inexact <= c_inexact;
      end
    end
  end
endmodule

// File: rtl/dti_checker.sv
module dti_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [63:0] in_data,
  input logic        in_mode64,
  input logic        in_wide,
  input logic        out_valid,
  input logic [63:0] out_result,
  input logic        out_invalid,
  input logic        out_inexact
);
  // R7: flags exclusive
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_invalid && out_inexact));

  // R9: strobe follows acceptance
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !out_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> ($stable(out_result) && $stable(out_invalid) && $stable(out_inexact)));

  // R8: narrow width leaves upper half zero
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !(in_mode64 && in_wide)) |=> (out_result[63:32] == 32'h0));

  // R3: narrow indefinite
  a_r3_narrow_indef: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !(in_mode64 && in_wide)) |=> (!out_invalid || out_result == 64'h8000_0000));

  // R4: wide indefinite
  a_r4_wide_indef: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode64 && in_wide) |=> (!out_invalid || out_result == 64'h8000_0000_0000_0000));

  // R5: NaN and infinity invalid
  a_r5_special_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (&in_data[62:52])) |=> out_invalid);

  // R6: zero exponent gives zero
  a_r6_zero_exp: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_data[62:52] == 11'h0)) |=> (out_result == 64'h0 && !out_invalid));
endmodule

bind dbl2int_trunc dti_checker u_chk (.*);

// File: tb/dbl2int_trunc_tb.sv
module dbl2int_trunc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic        in_mode64 = 1'b0;
  logic        in_wide = 1'b0;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_invalid;
  logic        out_inexact;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dbl2int_trunc u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_mode64(in_mode64), .in_wide(in_wide),
    .out_valid(out_valid), .out_result(out_result),
    .out_invalid(out_invalid), .out_inexact(out_inexact)
  );

  // reference: integer division on a 128-bit significand
  task automatic model(input logic [63:0] x, input bit wide,
                       output logic [63:0] res, output bit inv, output bit inx);
    logic [127:0] m, mag, dv, rem, lim;
    int e;
    bit neg;
    neg = x[63];
    inv = 0; inx = 0; res = '0; mag = '0;
    e = int'(x[62:52]) - 1023;
    m = {75'd0, 1'b1, x[51:0]};
    if (x[62:52] == 11'h7FF) inv = 1;
    else if (x[62:52] == 11'h0) inx = (x[51:0] != 0);
    else if (e < 0) inx = 1;
    else if (e > 70) inv = 1;
    else if (e >= 52) mag = m << (e - 52);
    else begin
      dv  = 128'd1 << (52 - e);
      mag = m / dv;
      rem = m % dv;
      inx = (rem != 0);
    end
    if (!inv) begin
      lim = wide ? (128'd1 << 63) : (128'd1 << 31);
      if (!neg) lim = lim - 1;
      if (mag > lim) inv = 1;
    end
    if (inv) begin
      inx = 0;
      res = wide ? 64'h8000_0000_0000_0000 : 64'h8000_0000;
    end else begin
      res = neg ? (64'd0 - mag[63:0]) : mag[63:0];
      if (!wide) res[63:32] = 32'h0;
    end
  endtask

  task automatic fail_line(input string req, input logic [65:0] act, input logic [65:0] exp_v,
                           input logic [63:0] x);
    fails++;
    $display("FAIL %s in=%h act=%h exp=%h", req, x, act, exp_v);
  endtask

  task automatic drive_one(input logic [63:0] x, input bit m64, input bit wd, input string req);
    logic [63:0] er;
    bit ei, ex;
    model(x, m64 && wd, er, ei, ex);
    in_data = x; in_mode64 = m64; in_wide = wd; in_valid = 1'b1;
    @(negedge clk);
    checks++;
    if (!out_valid || out_result !== er || out_invalid !== ei || out_inexact !== ex)
      fail_line(req, {out_invalid, out_inexact, out_result}, {ei, ex, er}, x);
  endtask

  function automatic logic [63:0] mk(input bit s, input int e, input logic [51:0] f);
    logic [10:0] ef;
    ef = 11'(e + 1023);
    return {s, ef, f};
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [51:0] pats [4];
    logic [63:0] hold_r;
    pats[0] = 52'h0; pats[1] = 52'hF_FFFF_FFFF_FFFF;
    pats[2] = 52'h1; pats[3] = 52'hA_5A5A_5C3C_3C3D;

    repeat (3) @(negedge clk);
    // R10 reset state
    checks++;
    if (out_valid !== 0 || out_result !== 0 || out_invalid !== 0 || out_inexact !== 0)
      fail_line("R10", {out_invalid, out_inexact, out_result}, 66'h0, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (in_ready !== 1'b1) fail_line("R9 ready", {65'h0, in_ready}, 66'h1, 64'h0);

    // R1 R3 R4 R7 R8 sweep over exponents, patterns, signs, widths
    for (int e = -3; e <= 70; e++)
      for (int p = 0; p < 4; p++)
        for (int s = 0; s < 2; s++) begin
          drive_one(mk(s[0], e, pats[p]), 1'b0, 1'b0, "R1/R3/R7/R8 narrow");
          drive_one(mk(s[0], e, pats[p]), 1'b0, 1'b1, "R2 wide ignored");
          drive_one(mk(s[0], e, pats[p]), 1'b1, 1'b0, "R2 narrow in mode64");
          drive_one(mk(s[0], e, pats[p]), 1'b1, 1'b1, "R1/R4/R7 wide");
        end

    // R3 boundaries: -2147483648.9 valid, +2^31 invalid
    drive_one(64'hC1E0_0000_001C_CCCD, 1'b0, 1'b0, "R3 most negative valid");
    checks++;
    if (out_invalid !== 0 || out_result !== 64'h8000_0000 || out_inexact !== 1)
      fail_line("R3 neg edge", {out_invalid, out_inexact, out_result}, {2'b01, 64'h8000_0000}, in_data);
    drive_one(mk(1'b0, 31, 52'h0), 1'b0, 1'b0, "R3 plus 2^31");
    checks++;
    if (out_invalid !== 1 || out_result !== 64'h8000_0000)
      fail_line("R3 pos edge", {out_invalid, out_inexact, out_result}, {2'b10, 64'h8000_0000}, in_data);
    // R4 boundaries
    drive_one(mk(1'b1, 63, 52'h0), 1'b1, 1'b1, "R4 minus 2^63 valid");
    drive_one(mk(1'b0, 63, 52'h0), 1'b1, 1'b1, "R4 plus 2^63");
    drive_one(64'h7FEF_FFFF_FFFF_FFFF, 1'b1, 1'b1, "R4 max finite");

    // R5 specials
    for (int w = 0; w < 3; w++) begin
      drive_one(64'h7FF0_0000_0000_0000, w == 2, w != 0, "R5 +inf");
      drive_one(64'hFFF0_0000_0000_0000, w == 2, w != 0, "R5 -inf");
      drive_one(64'h7FF8_0000_0000_0001, w == 2, w != 0, "R5 NaN");
      drive_one(64'hFFF0_0000_0000_0001, w == 2, w != 0, "R5 neg NaN");
    end

    // R6 zeros and denormals
    drive_one(64'h0, 1'b1, 1'b1, "R6 +0");
    drive_one(64'h8000_0000_0000_0000, 1'b0, 1'b0, "R6 -0");
    drive_one(64'h0000_0000_0000_0001, 1'b1, 1'b1, "R6 denormal");
    drive_one(64'h800F_FFFF_FFFF_FFFF, 1'b0, 1'b0, "R6 neg denormal");
    checks++;
    if (out_result !== 0 || out_inexact !== 1 || out_invalid !== 0)
      fail_line("R6 denorm flags", {out_invalid, out_inexact, out_result}, {2'b01, 64'h0}, in_data);

    // R9 idle cycles: strobe low, result held
    drive_one(mk(1'b1, 40, 52'h12345), 1'b1, 1'b1, "R9 setup");
    hold_r = out_result;
    in_valid = 1'b0;
    in_data = 64'h7FF0_0000_0000_0000;
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 0 || out_result !== hold_r || out_invalid !== 0)
        fail_line("R9 idle hold", {out_invalid, out_valid, out_result}, {2'b00, hold_r}, in_data);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule